// File: doc/BRIEF.md
# Serial NOR Flash Transaction Decoder

This block watches the byte stream of a serial NOR flash bus and turns it into decoded transaction events. A capture front end hands it one strobe per completed byte, carrying the byte driven by the controller (`mosi_byte`) and the byte returned by the flash (`miso_byte`). It also gives a separate strobe whenever chip select changes level. The decoder follows each command byte by byte. It reports the opcode, the assembled 24-bit address, dummy bytes, identification bytes returned by the flash, and data bytes, and it marks the first byte of each data phase.

Each opcode has its own byte layout. A per-opcode position sequencer chooses what every byte means from the current command and the byte's position within it. Commands of fixed length return the decoder to idle once their last byte has passed, so the next byte is taken as a new opcode. Read and program commands stream data until chip select changes. On each chip-select change the decoder emits a summary holding the most recent opcode and the number of bytes seen since the previous change. An opcode the decoder does not recognise is flagged and dropped.

Top module: `flash_txn_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every strobe output (`op_vld`, `unk_vld`, `addr_vld`, `dummy_vld`, `id_vld`, `data_vld`, `sum_vld`) is low.
- R2: The first byte after a chip-select change, or after a fixed-length command has completed, is taken as an opcode. For the known opcodes 0x03, 0x0B, 0x02, 0x20, 0x9F, 0xAB and 0x90, `op_vld` pulses with `op_code` equal to that byte. A byte position counter restarts at 1 for each opcode.
- R3: For opcodes 0x03, 0x0B, 0x02 and 0x20, the controller bytes at positions 2, 3 and 4 form `addr`, most significant byte first. `addr_vld` pulses on position 4, and `addr` does not change in a cycle that follows no accepted byte. Opcode 0x20 completes at position 4.
- R4: For opcode 0x0B, position 5 pulses `dummy_vld`. Data starts at position 6 and is taken from `miso_byte`.
- R5: For opcodes 0x03 (data from `miso_byte`) and 0x02 (data from `mosi_byte`), every byte from position 5 onwards pulses `data_vld` until chip select changes. `data_first` is high only on the first data byte of the command.
- R6: For opcode 0x9F, positions 2, 3 and 4 pulse `id_vld` with `id_byte` taken from `miso_byte`. `id_kind` is 0 (manufacturer), 1 (memory type) and 2 (device) in that order. The command then completes.
- R7: For opcode 0xAB, positions 2 to 4 are dummy bytes. Position 5 pulses `id_vld` with `id_kind` 2 and the `miso_byte` value, and the command then completes.
- R8: For opcode 0x90, positions 2 and 3 are dummy bytes and position 4 is a selector that produces no strobe. Positions 5 and 6 pulse `id_vld` with `miso_byte`. A selector of 0x00 gives kinds 0 then 2; any other selector gives kinds 2 then 0. The command then completes.
- R9: A byte in opcode position that is not a known opcode pulses `unk_vld` and not `op_vld`, and the following byte is again treated as an opcode.
- R10: A `cs_edge` pulse ends any command in progress, including one cut off mid-sequence. If at least one byte was accepted since the previous `cs_edge`, it also pulses `sum_vld` with `sum_count` equal to that number of bytes and `sum_op` equal to the most recent opcode-position byte. The next accepted byte is an opcode.
- R11: A byte strobe arriving in the same cycle as `cs_edge` is discarded. It produces no byte event and is not counted.
- R12: Every output event appears exactly one clock cycle after the input strobe that causes it, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A completed bus byte is present |
| mosi_byte | input | 8 | Byte driven by the controller |
| miso_byte | input | 8 | Byte returned by the flash |
| cs_edge | input | 1 | Chip select changed level |
| op_vld | output | 1 | Known opcode decoded |
| op_code | output | 8 | Decoded opcode |
| addr_vld | output | 1 | Address complete |
| addr | output | 24 | Assembled address |
| dummy_vld | output | 1 | Dummy byte seen |
| id_vld | output | 1 | Identification byte captured |
| id_kind | output | 2 | 0 manufacturer, 1 memory type, 2 device |
| id_byte | output | 8 | Identification value |
| data_vld | output | 1 | Data byte present |
| data_first | output | 1 | First byte of the data phase |
| data_byte | output | 8 | Data value |
| unk_vld | output | 1 | Unrecognised opcode dropped |
| sum_vld | output | 1 | Transaction summary present |
| sum_op | output | 8 | Most recent opcode byte |
| sum_count | output | 16 | Bytes accepted in the transaction |

## Verification
Directed sequences exercise every opcode layout at full length. They tell apart the sources of the address, dummy, ID and data bytes, including the MISO source for reads and the MOSI source for programs. Back-to-back fixed-length commands with no chip-select change separate correct completion from a sequencer that keeps counting. A chip-select change on an idle bus, a chip-select change mid-command, and a chip-select change that coincides with a byte separate the summary rules from each other. Seeded random transactions then mix opcodes, truncated lengths, selector values and unknown opcodes. These show that position tracking does not depend on what came before.

// File: rtl/flash_dec_pkg.sv
`timescale 1ns/1ps
package flash_dec_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_FREAD, CMD_PP, CMD_SE, CMD_RDID, CMD_RES, CMD_REMS
  } cmd_e;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_FREAD = 8'h0B;
  localparam logic [7:0] OPC_PP    = 8'h02;
  localparam logic [7:0] OPC_SE    = 8'h20;
  localparam logic [7:0] OPC_RDID  = 8'h9F;
  localparam logic [7:0] OPC_RES   = 8'hAB;
  localparam logic [7:0] OPC_REMS  = 8'h90;

  localparam int ADDR_BYTES = 3;
  localparam int ADDR_W     = ADDR_BYTES * 8;

  localparam logic [1:0] IDK_MFR  = 2'd0;
  localparam logic [1:0] IDK_TYPE = 2'd1;
  localparam logic [1:0] IDK_DEV  = 2'd2;

  typedef struct packed {
    logic       addr;
    logic       addr_last;
    logic       dummy;
    logic       sel;
    logic       id;
    logic [1:0] id_kind;
    logic       rems_slot;
    logic       rems_id;
    logic       data;
    logic       data_first;
    logic       data_miso;
    logic       last;
  } phase_t;

endpackage

// File: rtl/flash_op_lookup.sv
`timescale 1ns/1ps
module flash_op_lookup
  import flash_dec_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_e       cmd
);
  always_comb begin
    case (opcode)
      OPC_READ:  cmd = CMD_READ;
      OPC_FREAD: cmd = CMD_FREAD;
      OPC_PP:    cmd = CMD_PP;
      OPC_SE:    cmd = CMD_SE;
      OPC_RDID:  cmd = CMD_RDID;
      OPC_RES:   cmd = CMD_RES;
      OPC_REMS:  cmd = CMD_REMS;
      default:   cmd = CMD_NONE;
    endcase
  end
endmodule

// File: rtl/flash_pos_ctr.sv
`timescale 1ns/1ps
module flash_pos_ctr #(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             load_one,
  output logic [POS_W-1:0] pos_nx
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  // position of the byte currently offered; saturates for open-ended phases
  always_comb begin
    if (load_one)            pos_nx = POS_ONE;
    else if (pos_q == POS_MAX) pos_nx = pos_q;
    else                     pos_nx = pos_q + 1'b1;
  end

  always_comb begin
    pos_d = pos_q;
    if (clr)       pos_d = '0;
    else if (step) pos_d = pos_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end
endmodule

// File: rtl/flash_phase_decode.sv
`timescale 1ns/1ps
module flash_phase_decode
  import flash_dec_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  cmd_e             cmd,
  input  logic [POS_W-1:0] pos,
  output phase_t           ph
);
  localparam logic [POS_W-1:0] P_ADDR_LO = POS_W'(2);
  localparam logic [POS_W-1:0] P_ADDR_HI = POS_W'(1 + ADDR_BYTES);
  localparam logic [POS_W-1:0] P_AFTER   = POS_W'(2 + ADDR_BYTES);
  localparam logic [POS_W-1:0] P_FDATA   = POS_W'(3 + ADDR_BYTES);
  localparam logic [POS_W-1:0] P_RDID_HI = POS_W'(4);
  localparam logic [POS_W-1:0] P_RES_ID  = POS_W'(5);
  localparam logic [POS_W-1:0] P_REMS_SL = POS_W'(4);
  localparam logic [POS_W-1:0] P_REMS_ID = POS_W'(5);
  localparam logic [POS_W-1:0] P_REMS_HI = POS_W'(6);

  logic in_addr;
  assign in_addr = (pos >= P_ADDR_LO) && (pos <= P_ADDR_HI);

  always_comb begin
    ph = '0;
    case (cmd)
      CMD_READ, CMD_PP: begin
        ph.addr       = in_addr;
        ph.addr_last  = (pos == P_ADDR_HI);
        ph.data       = (pos >= P_AFTER);
        ph.data_first = (pos == P_AFTER);
        ph.data_miso  = (cmd == CMD_READ);
      end
      CMD_FREAD: begin
        ph.addr       = in_addr;
        ph.addr_last  = (pos == P_ADDR_HI);
        ph.dummy      = (pos == P_AFTER);
        ph.data       = (pos >= P_FDATA);
        ph.data_first = (pos == P_FDATA);
        ph.data_miso  = 1'b1;
      end
      CMD_SE: begin
        ph.addr      = in_addr;
        ph.addr_last = (pos == P_ADDR_HI);
        ph.last      = (pos == P_ADDR_HI);
      end
      CMD_RDID: begin
        ph.id      = (pos >= P_ADDR_LO) && (pos <= P_RDID_HI);
        ph.id_kind = 2'(pos - P_ADDR_LO);
        ph.last    = (pos == P_RDID_HI);
      end
      CMD_RES: begin
        ph.dummy   = (pos >= P_ADDR_LO) && (pos < P_RES_ID);
        ph.id      = (pos == P_RES_ID);
        ph.id_kind = IDK_DEV;
        ph.last    = (pos == P_RES_ID);
      end
      CMD_REMS: begin
        ph.dummy     = (pos >= P_ADDR_LO) && (pos < P_REMS_SL);
        ph.sel       = (pos == P_REMS_SL);
        ph.id        = (pos == P_REMS_ID) || (pos == P_REMS_HI);
        ph.rems_id   = ph.id;
        ph.rems_slot = (pos == P_REMS_HI);
        ph.last      = (pos == P_REMS_HI);
      end
      default: ph = '0;
    endcase
  end
endmodule

// File: rtl/flash_txn_decoder.sv
`timescale 1ns/1ps
module flash_txn_decoder
  import flash_dec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int POS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        mosi_byte,
  input  logic [7:0]        miso_byte,
  input  logic              cs_edge,
  output logic              op_vld,
  output logic [7:0]        op_code,
  output logic              addr_vld,
  output logic [ADDR_W-1:0] addr,
  output logic              dummy_vld,
  output logic              id_vld,
  output logic [1:0]        id_kind,
  output logic [7:0]        id_byte,
  output logic              data_vld,
  output logic              data_first,
  output logic [7:0]        data_byte,
  output logic              unk_vld,
  output logic              sum_vld,
  output logic [7:0]        sum_op,
  output logic [CNT_W-1:0]  sum_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cmd_e             cmd_q, cmd_d, lk_cmd, cur_cmd;
  logic [POS_W-1:0] pos_nx;
  phase_t           ph;
  logic             take, idle;
  logic             devfirst_q, devfirst_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]       lastop_q, lastop_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       kind_d;

  assign take    = byte_vld && !cs_edge;   // cs edge wins over a same-cycle byte
  assign idle    = (cmd_q == CMD_NONE);
  assign cur_cmd = idle ? lk_cmd : cmd_q;

  flash_op_lookup u_lookup (
    .opcode (mosi_byte),
    .cmd    (lk_cmd)
  );

  flash_pos_ctr #(.POS_W(POS_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cs_edge),
    .step     (take),
    .load_one (idle),
    .pos_nx   (pos_nx)
  );

  flash_phase_decode #(.POS_W(POS_W)) u_phase (
    .cmd (cur_cmd),
    .pos (pos_nx),
    .ph  (ph)
  );

  // next-state logic
  always_comb begin
    cmd_d      = cmd_q;
    devfirst_d = devfirst_q;
    addr_d     = addr_q;
    lastop_d   = lastop_q;
    cnt_d      = cnt_q;
    if (cs_edge) begin
      cmd_d = CMD_NONE;
      cnt_d = '0;
    end else if (take) begin
      cmd_d = ph.last ? CMD_NONE : cur_cmd;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (idle)     lastop_d = mosi_byte;
      if (ph.sel)   devfirst_d = (mosi_byte != 8'h00);
      if (ph.addr)  addr_d = {addr_q[ADDR_W-9:0], mosi_byte};
    end
  end

  always_comb begin
    kind_d = ph.id_kind;
    if (ph.rems_id) kind_d = (ph.rems_slot ^ devfirst_q) ? IDK_DEV : IDK_MFR;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= CMD_NONE;
      devfirst_q <= 1'b0;
      addr_q     <= '0;
      lastop_q   <= '0;
      cnt_q      <= '0;
    end else begin
      cmd_q      <= cmd_d;
      devfirst_q <= devfirst_d;
      addr_q     <= addr_d;
      lastop_q   <= lastop_d;
      cnt_q      <= cnt_d;
    end
  end

  // output strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_vld    <= 1'b0;
      unk_vld   <= 1'b0;
      addr_vld  <= 1'b0;
      dummy_vld <= 1'b0;
      id_vld    <= 1'b0;
      data_vld  <= 1'b0;
      data_first <= 1'b0;
      sum_vld   <= 1'b0;
    end else begin
      op_vld    <= take && idle && (lk_cmd != CMD_NONE);
      unk_vld   <= take && idle && (lk_cmd == CMD_NONE);
      addr_vld  <= take && ph.addr_last;
      dummy_vld <= take && ph.dummy;
      id_vld    <= take && ph.id;
      data_vld  <= take && ph.data;
      data_first <= take && ph.data_first;
      sum_vld   <= cs_edge && (cnt_q != '0);
    end
  end

  // output payloads, loaded under explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_code   <= '0;
      id_kind   <= '0;
      id_byte   <= '0;
      data_byte <= '0;
      sum_op    <= '0;
      sum_count <= '0;
    end else begin
      if (take && idle) op_code <= mosi_byte;
      if (take && ph.id) begin
        id_kind <= kind_d;
        id_byte <= miso_byte;
      end
      if (take && ph.data) data_byte <= ph.data_miso ? miso_byte : mosi_byte;
      if (cs_edge) begin
        sum_op    <= lastop_q;
        sum_count <= cnt_q;
      end
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/flash_txn_decoder_chk.sv
`timescale 1ns/1ps
module flash_txn_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             cs_edge,
  input logic             op_vld,
  input logic             addr_vld,
  input logic [23:0]      addr,
  input logic             dummy_vld,
  input logic             id_vld,
  input logic             data_vld,
  input logic             data_first,
  input logic             unk_vld,
  input logic             sum_vld,
  input logic [CNT_W-1:0] sum_count
);
  logic any_byte_ev;
  assign any_byte_ev = op_vld || unk_vld || addr_vld || dummy_vld || id_vld || data_vld;

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !(any_byte_ev || sum_vld));

  assert_one_event_per_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_vld, unk_vld, dummy_vld, id_vld, data_vld}));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_vld) |-> $stable(addr));

  assert_first_is_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_first |-> data_vld);

  assert_summary_follows_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld |-> ($past(cs_edge) && (sum_count != '0)));

  assert_cs_byte_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_edge) |-> !any_byte_ev);

  assert_event_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    any_byte_ev |-> $past(byte_vld && !cs_edge));
endmodule

bind flash_txn_decoder flash_txn_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld   (byte_vld),
  .cs_edge    (cs_edge),
  .op_vld     (op_vld),
  .addr_vld   (addr_vld),
  .addr       (addr),
  .dummy_vld  (dummy_vld),
  .id_vld     (id_vld),
  .data_vld   (data_vld),
  .data_first (data_first),
  .unk_vld    (unk_vld),
  .sum_vld    (sum_vld),
  .sum_count  (sum_count)
);

// File: tb/flash_txn_decoder_bench.sv
`timescale 1ns/1ps
module flash_txn_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, cs_edge;
  logic [7:0]  mosi_byte, miso_byte;
  logic        op_vld, addr_vld, dummy_vld, id_vld, data_vld, data_first, unk_vld, sum_vld;
  logic [7:0]  op_code, id_byte, data_byte, sum_op;
  logic [1:0]  id_kind;
  logic [23:0] addr;
  logic [15:0] sum_count;

  int   checks = 0;
  int   errors = 0;
  int   since_cs = 0;
  logic [7:0] last_op = 8'h00;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  flash_txn_decoder u_flash_txn_decoder (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
    .miso_byte(miso_byte), .cs_edge(cs_edge), .op_vld(op_vld), .op_code(op_code),
    .addr_vld(addr_vld), .addr(addr), .dummy_vld(dummy_vld), .id_vld(id_vld),
    .id_kind(id_kind), .id_byte(id_byte), .data_vld(data_vld), .data_first(data_first),
    .data_byte(data_byte), .unk_vld(unk_vld), .sum_vld(sum_vld), .sum_op(sum_op),
    .sum_count(sum_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [7:0] op);
    return op == 8'h03 || op == 8'h0B || op == 8'h02 || op == 8'h20 ||
           op == 8'h9F || op == 8'hAB || op == 8'h90;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op)
      8'h03: return "R5 read";
      8'h0B: return "R4 fastread";
      8'h02: return "R5 program";
      8'h20: return "R3 erase";
      8'h9F: return "R6 ident";
      8'hAB: return "R7 release-id";
      8'h90: return "R8 mfr-dev-id";
      default: return "R9 unknown";
    endcase
  endfunction

  // expected {op, unk, addr, dummy, id, data} for a byte at position pos
  function automatic logic [5:0] exp_flags(input logic [7:0] op, input int pos);
    logic [5:0] f;
    bit a_cmd;
    f = '0;
    a_cmd = (op == 8'h03 || op == 8'h0B || op == 8'h02 || op == 8'h20);
    if (pos == 1) begin
      if (is_known(op)) f[5] = 1'b1; else f[4] = 1'b1;
    end else begin
      f[3] = a_cmd && pos == 4;
      f[2] = (op == 8'h0B && pos == 5) || (op == 8'hAB && pos <= 4) || (op == 8'h90 && pos <= 3);
      f[1] = (op == 8'h9F && pos <= 4) || (op == 8'hAB && pos == 5) || (op == 8'h90 && pos >= 5);
      f[0] = ((op == 8'h03 || op == 8'h02) && pos >= 5) || (op == 8'h0B && pos >= 6);
    end
    return f;
  endfunction

  function automatic logic [1:0] exp_kind(input logic [7:0] op, input int pos, input logic [7:0] sel);
    if (op == 8'h9F) return 2'(pos - 2);
    if (op == 8'hAB) return 2'd2;
    if (pos == 5) return (sel == 8'h00) ? 2'd0 : 2'd2;
    return (sel == 8'h00) ? 2'd2 : 2'd0;
  endfunction

  task automatic put_byte(input logic [7:0] mo, input logic [7:0] mi);
    @(negedge clk);
    byte_vld = 1'b1; cs_edge = 1'b0; mosi_byte = mo; miso_byte = mi;
    @(posedge clk); #1;
    byte_vld = 1'b0;
    since_cs++;
  endtask

  task automatic pulse_cs(input bit with_byte, input logic [7:0] mo, input string tag);
    logic [5:0] f;
    @(negedge clk);
    cs_edge = 1'b1; byte_vld = with_byte; mosi_byte = mo; miso_byte = 8'h00;
    @(posedge clk); #1;
    cs_edge = 1'b0; byte_vld = 1'b0;
    f = {op_vld, unk_vld, addr_vld, dummy_vld, id_vld, data_vld};
    chk(f == 6'd0, {tag, " no byte event on cs"}, 32'(f), 0);
    chk(sum_vld == (since_cs != 0), {tag, " summary strobe"}, 32'(sum_vld), 32'(since_cs != 0));
    if (since_cs != 0) begin
      chk(sum_count == 16'(since_cs), {tag, " summary count"}, 32'(sum_count), 32'(since_cs));
      chk(sum_op == last_op, {tag, " summary opcode"}, 32'(sum_op), 32'(last_op));
    end
    since_cs = 0;
  endtask

  // runs one command of len bytes and checks every byte event
  task automatic run_txn(input logic [7:0] op, input int len, input logic [7:0] sel, input bit end_cs);
    logic [7:0]  mo, mi;
    logic [5:0]  f, e;
    logic [23:0] ea;
    string       tg;
    ea = '0;
    tg = tag_of(op);
    for (int p = 1; p <= len; p++) begin
      mi = 8'($urandom);
      mo = (p == 1) ? op : (op == 8'h90 && p == 4) ? sel : 8'($urandom);
      if (p >= 2 && p <= 4) ea = {ea[15:0], mo};
      put_byte(mo, mi);
      if (p == 1) last_op = op;
      f = {op_vld, unk_vld, addr_vld, dummy_vld, id_vld, data_vld};
      e = exp_flags(op, p);
      chk(f == e, (p == 1) ? {tg, " R2 opcode position"} : {tg, " event flags"}, 32'(f), 32'(e));
      if (e[5]) chk(op_code == op, {tg, " R2 opcode value"}, 32'(op_code), 32'(op));
      if (e[3]) chk(addr == ea, {tg, " R3 address"}, 32'(addr), 32'(ea));
      if (e[1]) begin
        chk(id_byte == mi, {tg, " id byte"}, 32'(id_byte), 32'(mi));
        chk(id_kind == exp_kind(op, p, sel), {tg, " id kind"}, 32'(id_kind), 32'(exp_kind(op, p, sel)));
      end
      if (e[0]) begin
        chk(data_byte == ((op == 8'h02) ? mo : mi), {tg, " data byte"}, 32'(data_byte),
            32'((op == 8'h02) ? mo : mi));
        chk(data_first == (p == ((op == 8'h0B) ? 6 : 5)), {tg, " data first marker"},
            32'(data_first), 32'(p == ((op == 8'h0B) ? 6 : 5)));
      end
    end
    if (end_cs) pulse_cs(1'b0, 8'h00, {tg, " R10"});
  endtask

  initial begin
    logic [7:0] ops [8];
    int         full [8];
    logic [5:0] f;
    ops = '{8'h03, 8'h0B, 8'h02, 8'h20, 8'h9F, 8'hAB, 8'h90, 8'h5A};
    full = '{12, 12, 12, 4, 4, 5, 6, 1};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; byte_vld = 1'b0; cs_edge = 1'b0; mosi_byte = '0; miso_byte = '0;
    repeat (3) @(posedge clk);
    #1;
    f = {op_vld, unk_vld, addr_vld, dummy_vld, id_vld, data_vld};
    chk(f == 0 && !sum_vld, "R1 reset quiet", 32'(f), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    f = {op_vld, unk_vld, addr_vld, dummy_vld, id_vld, data_vld};
    chk(f == 0 && !sum_vld, "R1 quiet after release", 32'(f), 0);

    // every layout at full length
    run_txn(8'h03, 8, 8'h00, 1'b1);
    run_txn(8'h0B, 9, 8'h00, 1'b1);
    run_txn(8'h02, 7, 8'h00, 1'b1);
    run_txn(8'hAB, 5, 8'h00, 1'b1);
    run_txn(8'h90, 6, 8'h00, 1'b1);
    run_txn(8'h90, 6, 8'h01, 1'b1);
    run_txn(8'h90, 6, 8'h7F, 1'b1);
    // fixed-length commands chain without chip-select change (R2, R6)
    run_txn(8'h20, 4, 8'h00, 1'b0);
    run_txn(8'h9F, 4, 8'h00, 1'b0);
    run_txn(8'h03, 6, 8'h00, 1'b1);
    // unknown opcode then a new opcode (R9)
    run_txn(8'h5A, 1, 8'h00, 1'b0);
    run_txn(8'h9F, 4, 8'h00, 1'b1);
    // chip-select change with nothing accepted (R10)
    pulse_cs(1'b0, 8'h00, "R10 idle cs");
    // abort mid-address, then a fresh opcode (R10)
    run_txn(8'h0B, 3, 8'h00, 1'b1);
    run_txn(8'h20, 4, 8'h00, 1'b1);
    // byte coinciding with cs edge is dropped (R11)
    run_txn(8'h03, 3, 8'h00, 1'b0);
    pulse_cs(1'b1, 8'h9F, "R11 collision");
    run_txn(8'h9F, 4, 8'h00, 1'b1);
    // one-cycle event width (R12)
    run_txn(8'h03, 6, 8'h00, 1'b0);
    @(posedge clk); #1;
    f = {op_vld, unk_vld, addr_vld, dummy_vld, id_vld, data_vld};
    chk(f == 0, "R12 events last one cycle", 32'(f), 0);
    pulse_cs(1'b0, 8'h00, "R12 R10");

    // seeded random mix
    for (int t = 0; t < 80; t++) begin
      int k;
      int n;
      k = int'($urandom % 8);
      n = 1 + int'($urandom % full[k]);
      run_txn(ops[k], n, (($urandom % 2) == 0) ? 8'h00 : 8'($urandom), 1'b1);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule